// File: doc/BRIEF.md
# Xon/Xoff Software Flow-Control Engine

This block adds in-band software flow control to one serial channel. Software loads four 8-bit flow characters and a 4-bit control code through a small write port. Each character the receiver delivers is compared against the selected resume and pause patterns. A match pauses or releases the local transmitter, and the matching character is flagged so that the caller can drop it from the receive data path.

In the other direction, the block sends flow characters to the far end. A pulse on the resume or pause request makes it offer one or two flow characters to the transmitter over a request/acknowledge handshake. The transmit and receive halves of the control code are decoded independently. A two-character mode treats the two characters of a kind as one sequence, both when sending and when matching.

The transmitter consults a single go signal. That signal is low while a flow character is waiting and while the channel is paused, so flow characters take priority over normal data at the next character boundary. A pause or release only reaches the transmitter at a boundary the transmitter reports, so a character already being shifted out completes.

Top module: `swfc_engine`

## Requirements
- R1: After reset, all four flow characters and the control code are 0, tx_hold_o, fc_req_o and rx_consumed_o are 0, and tx_go_o is 1.
- R2: A write with cfg_we_i high loads cfg_wdata_i into the register selected by cfg_addr_i: 0 resume-A, 1 resume-B, 2 pause-A, 3 pause-B. Address 4 loads cfg_wdata_i[3:0] into the control code. A write to the control code cancels any half-matched receive sequence.
- R3: Control bits [1:0] select receive matching. 00 disables matching. 10 matches single characters against resume-A/pause-A. 01 matches single characters against resume-B/pause-B.
- R4: With control bits [1:0] = 11, a match requires the A character followed by the B character of the same kind as the very next received character. Any other character in between cancels the partial match. Only the completing character counts as matched.
- R5: A pause match sets the internal pause state, and a resume match clears it. If one character matches both, the pause wins. While receive matching is disabled (bits [1:0] = 00), the pause state is cleared.
- R6: rx_consumed_o is high for exactly the cycle after a strobed character that produced a match, and is low otherwise.
- R7: tx_hold_o takes the pause state only on a clock edge where tx_boundary_i is high, and holds its value otherwise.
- R8: Control bits [3:2] select sending. 10 sends the A character, 01 sends the B character, and 11 sends A then B. The characters are resume-A/B for a resume request and pause-A/B for a pause request.
- R9: fc_req_o rises the cycle after a request and stays high with fc_data_o steady until fc_ack_i. With bits [3:2] = 00, requests are ignored. A simultaneous resume and pause request is taken as pause.
- R10: A request that arrives while a sequence is in flight is held in a one-entry slot, where a later request replaces an earlier one. It starts when the current sequence completes, and a request in that same final cycle replaces the held one.
- R11: tx_go_o is high only when neither tx_hold_o nor fc_req_o is high. Flow characters are offered even while the channel is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_consumed_o | output | 1 | Previous received character was a flow match |
| tx_boundary_i | input | 1 | Transmitter is between characters |
| tx_hold_o | output | 1 | Transmitter paused |
| tx_go_o | output | 1 | Transmitter may load normal data |
| send_xon_i | input | 1 | Request a resume sequence to the far end |
| send_xoff_i | input | 1 | Request a pause sequence to the far end |
| fc_req_o | output | 1 | Flow character waiting to be sent |
| fc_data_o | output | 8 | Flow character to send |
| fc_ack_i | input | 1 | Transmitter took fc_data_o |

## Verification
rx_consumed_o is due one cycle after the strobe. The internal pause state updates on that same edge, so tx_hold_o follows one edge later when tx_boundary_i is high. fc_req_o and fc_data_o appear one cycle after a request, and each acknowledge moves to the next character or ends the sequence by the following cycle. The bench drives every input on the falling clock edge and samples on the next falling edge, so each check lands on the cycle its register chain predicts. The bench sweeps every receive mode against every ordered pair drawn from a five-character alphabet and compares the results with an arithmetic model.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic {FC_XON = 1'b0, FC_XOFF = 1'b1} fc_kind_e;

  localparam int unsigned IDX_XON_A  = 0;
  localparam int unsigned IDX_XON_B  = 1;
  localparam int unsigned IDX_XOFF_A = 2;
  localparam int unsigned IDX_XOFF_B = 3;
  localparam int unsigned NUM_CHARS  = 4;
  localparam int unsigned CTRL_W     = 4;

  // selects character index for a kind and position in the sequence
  function automatic int unsigned char_idx(fc_kind_e kind, logic use_b);
    if (kind == FC_XOFF) return use_b ? IDX_XOFF_B : IDX_XOFF_A;
    return use_b ? IDX_XON_B : IDX_XON_A;
  endfunction
endpackage

// File: rtl/swfc_regs.sv
module swfc_regs
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned AW     = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [CHAR_W-1:0]                  wdata_i,
  output logic [NUM_CHARS-1:0][CHAR_W-1:0]   chars_o,
  output logic [CTRL_W-1:0]                  ctrl_o,
  output logic                               ctrl_wr_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_CHARS);

  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         chars_o[g] <= '0;
      else if (we_i && addr_i == AW'(g))   chars_o[g] <= wdata_i;
    end
  end

  assign ctrl_wr_o = we_i && addr_i == CTRL_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_wr_o) ctrl_o <= wdata_i[CTRL_W-1:0];
  end
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars_i,
  input  logic [1:0]                       mode_i,
  input  logic                             ctrl_wr_i,
  input  logic                             valid_i,
  input  logic [CHAR_W-1:0]                data_i,
  output logic                             pause_o,
  output logic                             consumed_o
);
  logic single, use_b, dual;
  logic arm_on_q, arm_off_q;
  logic hit_on, hit_off;
  logic [CHAR_W-1:0] on_c, off_c;

  assign dual   = mode_i == 2'b11;
  assign single = mode_i == 2'b10 || mode_i == 2'b01;
  assign use_b  = mode_i == 2'b01;
  assign on_c   = use_b ? chars_i[IDX_XON_B]  : chars_i[IDX_XON_A];
  assign off_c  = use_b ? chars_i[IDX_XOFF_B] : chars_i[IDX_XOFF_A];

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    if (valid_i) begin
      if (single) begin
        hit_on  = data_i == on_c;
        hit_off = data_i == off_c;
      end else if (dual) begin
        hit_on  = arm_on_q  && data_i == chars_i[IDX_XON_B];
        hit_off = arm_off_q && data_i == chars_i[IDX_XOFF_B];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_on_q  <= 1'b0;
      arm_off_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      arm_on_q  <= 1'b0;
      arm_off_q <= 1'b0;
    end else if (valid_i) begin
      // any character that does not complete a match restarts the sequence
      arm_on_q  <= dual && data_i == chars_i[IDX_XON_A]  && !(hit_on || hit_off);
      arm_off_q <= dual && data_i == chars_i[IDX_XOFF_A] && !(hit_on || hit_off);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_o    <= 1'b0;
      consumed_o <= 1'b0;
    end else begin
      consumed_o <= hit_on || hit_off;
      if (hit_off)              pause_o <= 1'b1;
      else if (hit_on)          pause_o <= 1'b0;
      else if (mode_i == 2'b00) pause_o <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_send_seq.sv
module swfc_send_seq
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars_i,
  input  logic [1:0]                       mode_i,
  input  logic                             send_xon_i,
  input  logic                             send_xoff_i,
  input  logic                             ack_i,
  output logic                             req_o,
  output logic [CHAR_W-1:0]                data_o
);
  logic     busy_q, sel_b_q, pend_q;
  fc_kind_e kind_q, pend_kind_q, req_kind;
  logic     dual, req_v, step_ok, last, free, start_b;

  assign dual     = mode_i == 2'b11;
  assign start_b  = mode_i == 2'b01;
  assign req_v    = mode_i != 2'b00 && (send_xon_i || send_xoff_i);
  assign req_kind = send_xoff_i ? FC_XOFF : FC_XON;
  assign step_ok  = busy_q && ack_i;
  assign last     = step_ok && !(dual && !sel_b_q);
  assign free     = !busy_q || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      sel_b_q     <= 1'b0;
      pend_q      <= 1'b0;
      kind_q      <= FC_XON;
      pend_kind_q <= FC_XON;
    end else if (free) begin
      pend_q <= 1'b0;
      if (req_v) begin
        busy_q  <= 1'b1;
        kind_q  <= req_kind;
        sel_b_q <= start_b;
      end else if (pend_q) begin
        busy_q  <= mode_i != 2'b00;
        kind_q  <= pend_kind_q;
        sel_b_q <= start_b;
      end else begin
        busy_q  <= 1'b0;
      end
    end else begin
      if (step_ok) sel_b_q <= 1'b1;
      if (req_v) begin
        pend_q      <= 1'b1;
        pend_kind_q <= req_kind;
      end
    end
  end

  assign req_o  = busy_q;
  assign data_o = chars_i[char_idx(kind_q, sel_b_q)];
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [CHAR_W-1:0] cfg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              rx_consumed_o,
  input  logic              tx_boundary_i,
  output logic              tx_hold_o,
  output logic              tx_go_o,
  input  logic              send_xon_i,
  input  logic              send_xoff_i,
  output logic              fc_req_o,
  output logic [CHAR_W-1:0] fc_data_o,
  input  logic              fc_ack_i
);
  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars;
  logic [CTRL_W-1:0]                ctrl;
  logic                             ctrl_wr;
  logic                             pause;

  swfc_regs #(.CHAR_W(CHAR_W), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .chars_o(chars), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr)
  );

  swfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i, .rst_ni,
    .chars_i(chars), .mode_i(ctrl[1:0]), .ctrl_wr_i(ctrl_wr),
    .valid_i(rx_valid_i), .data_i(rx_data_i),
    .pause_o(pause), .consumed_o(rx_consumed_o)
  );

  swfc_send_seq #(.CHAR_W(CHAR_W)) u_tx (
    .clk_i, .rst_ni,
    .chars_i(chars), .mode_i(ctrl[3:2]),
    .send_xon_i, .send_xoff_i, .ack_i(fc_ack_i),
    .req_o(fc_req_o), .data_o(fc_data_o)
  );

  // pause reaches the transmitter only between characters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tx_hold_o <= 1'b0;
    else if (tx_boundary_i) tx_hold_o <= pause;
  end

  assign tx_go_o = !tx_hold_o && !fc_req_o;
endmodule

// File: rtl/swfc_engine_chk.sv
module swfc_engine_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              rx_valid_i,
  input logic              rx_consumed_o,
  input logic              tx_boundary_i,
  input logic              tx_hold_o,
  input logic              send_xon_i,
  input logic              send_xoff_i,
  input logic              fc_req_o,
  input logic [CHAR_W-1:0] fc_data_o,
  input logic              fc_ack_i
);
  // R6
  consumed_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_consumed_o |-> $past(rx_valid_i));

  // R7
  hold_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_hold_o) |-> $past(tx_boundary_i));

  // R9
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_req_o && !fc_ack_i && !cfg_we_i) |=> (fc_req_o && $stable(fc_data_o)));

  // R9
  req_needs_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fc_req_o) |-> $past(send_xon_i || send_xoff_i));
endmodule

bind swfc_engine swfc_engine_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .rx_valid_i(rx_valid_i),
  .rx_consumed_o(rx_consumed_o), .tx_boundary_i(tx_boundary_i), .tx_hold_o(tx_hold_o),
  .send_xon_i(send_xon_i), .send_xoff_i(send_xoff_i), .fc_req_o(fc_req_o),
  .fc_data_o(fc_data_o), .fc_ack_i(fc_ack_i)
);

// File: tb/sim_swfc_engine.sv
module sim_swfc_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_consumed;
  logic       tx_boundary = 1'b1;
  logic       tx_hold, tx_go;
  logic       send_xon = 1'b0, send_xoff = 1'b0;
  logic       fc_req;
  logic [7:0] fc_data;
  logic       fc_ack = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  localparam logic [7:0] XA = 8'h11, XB = 8'h22, FA = 8'h13, FB = 8'h24, JK = 8'h55;

  always #5 clk = ~clk;

  swfc_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_consumed_o(rx_consumed), .tx_boundary_i(tx_boundary), .tx_hold_o(tx_hold),
    .tx_go_o(tx_go), .send_xon_i(send_xon), .send_xoff_i(send_xoff),
    .fc_req_o(fc_req), .fc_data_o(fc_data), .fc_ack_i(fc_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rxc(input logic [7:0] c, input logic exp_cons, input string req);
    rx_valid = 1'b1; rx_data = c;
    step();
    rx_valid = 1'b0;
    chk(req, 32'(rx_consumed), 32'(exp_cons));
  endtask

  function automatic logic [7:0] tx_char(input logic off, input logic second, input int txm);
    logic use_b;
    use_b = (txm == 1) || second;
    if (off) return use_b ? FB : FA;
    return use_b ? XB : XA;
  endfunction

  task automatic tx_run(input logic off, input int txm);
    wr(3'd4, 8'(txm << 2));
    if (off) send_xoff = 1'b1; else send_xon = 1'b1;
    step();
    send_xoff = 1'b0; send_xon = 1'b0;
    chk("R8 req", 32'(fc_req), 1);
    chk("R8 first char", 32'(fc_data), 32'(tx_char(off, 1'b0, txm)));
    chk("R11 go low", 32'(tx_go), 0);
    step();
    chk("R9 held", 32'(fc_data), 32'(tx_char(off, 1'b0, txm)));
    fc_ack = 1'b1; step(); fc_ack = 1'b0;
    if (txm == 3) begin
      chk("R8 second req", 32'(fc_req), 1);
      chk("R8 second char", 32'(fc_data), 32'(tx_char(off, 1'b1, txm)));
      fc_ack = 1'b1; step(); fc_ack = 1'b0;
    end
    chk("R8 done", 32'(fc_req), 0);
    chk("R11 go high", 32'(tx_go), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic arm_on, arm_off, pause, dual, hon, hoff;
    logic [7:0] alpha [5];
    alpha[0] = XA; alpha[1] = XB; alpha[2] = FA; alpha[3] = FB; alpha[4] = JK;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hold", 32'(tx_hold), 0);
    chk("R1 req", 32'(fc_req), 0);
    chk("R1 consumed", 32'(rx_consumed), 0);
    chk("R1 go", 32'(tx_go), 1);
    wr(3'd4, 8'h0C);
    send_xoff = 1'b1; step(); send_xoff = 1'b0;
    chk("R1 chars zero", 32'(fc_data), 0);
    fc_ack = 1'b1; step(); fc_ack = 1'b0;
    chk("R1 char B zero", 32'(fc_data), 0);
    fc_ack = 1'b1; step(); fc_ack = 1'b0;

    // R2 load characters
    wr(3'd0, XA); wr(3'd1, XB); wr(3'd2, FA); wr(3'd3, FB);

    // R3 R4 R5 R6 sweep of every receive mode over all ordered pairs
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          wr(3'd4, 8'h00);
          wr(3'd4, 8'(m));
          arm_on = 0; arm_off = 0; pause = 0;
          dual = (m == 3);
          for (int k = 0; k < 2; k++) begin
            logic [7:0] c;
            c = (k == 0) ? alpha[i] : alpha[j];
            if (m == 2 || m == 1) begin
              hon  = c == ((m == 2) ? XA : XB);
              hoff = c == ((m == 2) ? FA : FB);
            end else begin
              hon  = dual && arm_on && c == XB;
              hoff = dual && arm_off && c == FB;
            end
            arm_on  = dual && c == XA && !(hon || hoff);
            arm_off = dual && c == FA && !(hon || hoff);
            if (hoff) pause = 1; else if (hon) pause = 0;
            rxc(c, hon || hoff, dual ? "R4 R6 consumed" : "R3 R6 consumed");
          end
          step();
          chk("R5 hold after pair", 32'(tx_hold), 32'(pause));
        end
      end
    end

    // R4 a control write cancels a half-matched sequence
    wr(3'd4, 8'h03);
    rxc(FA, 0, "R4 first");
    wr(3'd4, 8'h03);
    rxc(FB, 0, "R4 cancelled by write");

    // R7 pause waits for a character boundary
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h02);
    step();
    tx_boundary = 1'b0;
    rxc(FA, 1, "R7 consumed");
    repeat (3) step();
    chk("R7 no boundary hold", 32'(tx_hold), 0);
    chk("R11 go while unpaused", 32'(tx_go), 1);
    tx_boundary = 1'b1;
    step();
    chk("R7 boundary hold", 32'(tx_hold), 1);
    chk("R11 go paused", 32'(tx_go), 0);
    rxc(XA, 1, "R5 resume consumed");
    step();
    chk("R5 resume", 32'(tx_hold), 0);

    // R5 a character matching both kinds pauses
    wr(3'd0, 8'h77); wr(3'd2, 8'h77);
    rxc(8'h77, 1, "R5 both consumed");
    step();
    chk("R5 pause wins", 32'(tx_hold), 1);
    wr(3'd4, 8'h00);
    step(); step();
    chk("R5 disable releases", 32'(tx_hold), 0);
    wr(3'd0, XA); wr(3'd2, FA);

    // R8 every send mode and kind
    for (int t = 1; t < 4; t++) begin
      tx_run(1'b0, t);
      tx_run(1'b1, t);
    end

    // R9 mode 00 ignores requests, pause beats resume
    wr(3'd4, 8'h00);
    send_xon = 1'b1; step(); send_xon = 1'b0;
    chk("R9 ignored", 32'(fc_req), 0);
    wr(3'd4, 8'h08);
    send_xon = 1'b1; send_xoff = 1'b1; step(); send_xon = 1'b0; send_xoff = 1'b0;
    chk("R9 pause wins", 32'(fc_data), 32'(FA));
    fc_ack = 1'b1; step(); fc_ack = 1'b0;
    chk("R9 done", 32'(fc_req), 0);

    // R10 held request, latest wins, started after current sequence
    wr(3'd4, 8'h0C);
    send_xon = 1'b1; step(); send_xon = 1'b0;
    chk("R10 first", 32'(fc_data), 32'(XA));
    send_xon = 1'b1; step(); send_xon = 1'b0;
    send_xoff = 1'b1; step(); send_xoff = 1'b0;
    chk("R10 no preempt", 32'(fc_data), 32'(XA));
    fc_ack = 1'b1; step();
    chk("R10 second of current", 32'(fc_data), 32'(XB));
    step();
    chk("R10 held starts", 32'(fc_data), 32'(FA));
    chk("R10 held req", 32'(fc_req), 1);
    step();
    chk("R10 held second", 32'(fc_data), 32'(FB));
    step(); fc_ack = 1'b0;
    chk("R10 drained", 32'(fc_req), 0);

    // R11 flow characters offered while paused
    wr(3'd4, 8'h0A);
    rxc(FA, 1, "R11 pause consumed");
    step();
    send_xon = 1'b1; step(); send_xon = 1'b0;
    chk("R11 req while paused", 32'(fc_req), 1);
    chk("R11 go low", 32'(tx_go), 0);
    fc_ack = 1'b1; step(); fc_ack = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule